// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between a CPU's 16-bit address bus and the storage behind it. Each request is sorted into one of several regions, and the block drives the matching target with a local address:
- cartridge space, which goes out through an external port;
- video RAM, with a selectable half;
- a fixed work RAM bank;
- a selectable work RAM bank;
- a mirror window;
- the sprite attribute table;
- an unusable hole;
- the I/O and high-RAM page.

Two bank-select registers live in the I/O page. Software writes them with ordinary stores. They remap the video and switchable work RAM windows from the next request on.

The RAM arrays sit outside the block as synchronous memories. Every target returns read data on the clock edge after the request. The block registers which target was read and steers that target's data to the CPU. A single-cycle valid strobe marks the returned data. At most one target is enabled per request. A shared write-enable and write-data pair serves all targets.

Top module: `memmap_decoder`

## Requirements
- R1: Requests to 0x0000-0x7FFF and 0xA000-0xBFFF assert `cart_req`, with `cart_addr` equal to the CPU address and `mem_we` following `cpu_we`.
- R2: Requests to 0x8000-0x9FFF assert `vram_en` with `vram_addr = {vbank, addr[12:0]}`, where vbank is bit 0 of the video-bank register.
- R3: Requests to 0xC000-0xCFFF assert `wram_en` with `wram_addr = addr[11:0]`, whatever the work-bank register holds.
- R4: Requests to 0xD000-0xDFFF assert `wram_en` with `wram_addr = {b, addr[11:0]}`, where b is bits 2:0 of the work-bank register. A value of 0 is replaced by 1.
- R5: Requests to 0xE000-0xFDFF assert `wram_en` with `wram_addr = addr - 0xE000`, independent of the bank registers. As a result, 0xF000-0xFDFF lands on physical 0x1000-0x1DFF.
- R6: Requests to 0xFE00-0xFE9F assert `oam_en` with `oam_addr = addr[7:0]`.
- R7: Reads from 0xFEA0-0xFEFF return 0xFF with `cpu_rvalid`. Writes there enable no target and change no stored state.
- R8: Requests to 0xFF00-0xFFFF, other than the two bank-register addresses, assert `hram_en` with `hram_addr = addr[7:0]`.
- R9: The video-bank register is at 0xFF4F and keeps bit 0 of a written byte. The work-bank register is at 0xFF70 and keeps bits 2:0. Reads return the kept bits with all other bits zero. Accesses to these addresses enable no target.
- R10: After reset both bank registers read 0. Video bank 0 and work bank 1 are therefore in effect.
- R11: A read accepted at one clock edge raises `cpu_rvalid` for exactly one cycle after that edge, carrying the target's data. Writes never raise `cpu_rvalid`.
- R12: At most one of `cart_req`, `vram_en`, `wram_en`, `oam_en`, `hram_en` is high in any cycle, and none is high while `cpu_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data strobe, one cycle after the request |
| mem_we | output | 1 | Write enable shared by all targets |
| mem_wdata | output | 8 | Write data shared by all targets |
| cart_req | output | 1 | Cartridge access enable |
| cart_addr | output | 16 | Cartridge address (CPU address unchanged) |
| cart_rdata | input | 8 | Cartridge read data, one cycle latency |
| vram_en | output | 1 | Video RAM enable |
| vram_addr | output | 14 | Video RAM local address |
| vram_rdata | input | 8 | Video RAM read data |
| wram_en | output | 1 | Work RAM enable |
| wram_addr | output | 15 | Work RAM local address |
| wram_rdata | input | 8 | Work RAM read data |
| oam_en | output | 1 | Sprite table enable |
| oam_addr | output | 8 | Sprite table local address |
| oam_rdata | input | 8 | Sprite table read data |
| hram_en | output | 1 | I/O and high-RAM page enable |
| hram_addr | output | 8 | I/O page local address |
| hram_rdata | input | 8 | I/O page read data |

## Verification
The hardest case to reach from the ports is aliasing between windows that share one physical array. This covers the selectable work bank against the mirror, whose upper half reaches physical bank 1 whatever bank is selected. It also covers a zero bank value that must behave like one. The stimulus writes distinct bytes through one window under one bank setting. It then changes the bank registers with ordinary stores and reads back through another window. Each read-back value exposes which physical byte was actually hit.

// File: rtl/memmap_decoder.sv
module memmap_decoder #(
  parameter logic [7:0] VBANK_REG = 8'h4F,
  parameter logic [7:0] WBANK_REG = 8'h70,
  parameter logic [7:0] OAM_LAST  = 8'h9F,
  parameter int VRAM_AW = 14,
  parameter int WRAM_AW = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic               cpu_rvalid,
  output logic               mem_we,
  output logic [7:0]         mem_wdata,
  output logic               cart_req,
  output logic [15:0]        cart_addr,
  input  logic [7:0]         cart_rdata,
  output logic               vram_en,
  output logic [VRAM_AW-1:0] vram_addr,
  input  logic [7:0]         vram_rdata,
  output logic               wram_en,
  output logic [WRAM_AW-1:0] wram_addr,
  input  logic [7:0]         wram_rdata,
  output logic               oam_en,
  output logic [7:0]         oam_addr,
  input  logic [7:0]         oam_rdata,
  output logic               hram_en,
  output logic [7:0]         hram_addr,
  input  logic [7:0]         hram_rdata
);
  localparam int VWIN_W  = 13;
  localparam int WWIN_W  = 12;
  localparam int VBANK_W = VRAM_AW - VWIN_W;
  localparam int WBANK_W = WRAM_AW - WWIN_W;

  typedef enum logic [2:0] {
    RG_CART, RG_VRAM, RG_WRAM, RG_OAM, RG_HOLE, RG_HRAM, RG_BANKV, RG_BANKW
  } region_t;

  region_t              region, rsel_q;
  logic [VBANK_W-1:0]   vbank_q;
  logic [WBANK_W-1:0]   wbank_q, wbank_eff;
  logic [7:0]           bank_rd_q;
  logic                 rd_go, wr_go;

  always_comb begin
    if (!cpu_addr[15] || cpu_addr[15:13] == 3'b101)  region = RG_CART;
    else if (cpu_addr[15:13] == 3'b100)              region = RG_VRAM;
    else if (cpu_addr[15:13] == 3'b110)              region = RG_WRAM;
    else if (cpu_addr[12:9] != 4'hF)                 region = RG_WRAM;
    else if (!cpu_addr[8])                           region = (cpu_addr[7:0] <= OAM_LAST) ? RG_OAM : RG_HOLE;
    else if (cpu_addr[7:0] == VBANK_REG)             region = RG_BANKV;
    else if (cpu_addr[7:0] == WBANK_REG)             region = RG_BANKW;
    else                                             region = RG_HRAM;
  end

  assign rd_go     = cpu_req && !cpu_we;
  assign wr_go     = cpu_req && cpu_we;
  assign wbank_eff = (wbank_q == '0) ? WBANK_W'(1) : wbank_q;

  assign mem_we    = wr_go;
  assign mem_wdata = cpu_wdata;

  assign cart_req  = cpu_req && region == RG_CART;
  assign vram_en   = cpu_req && region == RG_VRAM;
  assign wram_en   = cpu_req && region == RG_WRAM;
  assign oam_en    = cpu_req && region == RG_OAM;
  assign hram_en   = cpu_req && region == RG_HRAM;

  assign cart_addr = cpu_addr;
  assign vram_addr = {vbank_q, cpu_addr[VWIN_W-1:0]};
  assign wram_addr = cpu_addr[13] ? WRAM_AW'(cpu_addr[12:0]) :
                     cpu_addr[12] ? {wbank_eff, cpu_addr[WWIN_W-1:0]} :
                                    WRAM_AW'(cpu_addr[WWIN_W-1:0]);
  assign oam_addr  = cpu_addr[7:0];
  assign hram_addr = cpu_addr[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbank_q    <= '0;
      wbank_q    <= '0;
      rsel_q     <= RG_CART;
      cpu_rvalid <= 1'b0;
      bank_rd_q  <= '0;
    end else begin
      if (wr_go && region == RG_BANKV) vbank_q <= cpu_wdata[VBANK_W-1:0];
      if (wr_go && region == RG_BANKW) wbank_q <= cpu_wdata[WBANK_W-1:0];
      cpu_rvalid <= rd_go;
      if (rd_go) begin
        rsel_q    <= region;
        bank_rd_q <= (region == RG_BANKV) ? 8'(vbank_q) : 8'(wbank_q);
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RG_CART:  cpu_rdata = cart_rdata;
      RG_VRAM:  cpu_rdata = vram_rdata;
      RG_WRAM:  cpu_rdata = wram_rdata;
      RG_OAM:   cpu_rdata = oam_rdata;
      RG_HRAM:  cpu_rdata = hram_rdata;
      RG_HOLE:  cpu_rdata = 8'hFF;
      default:  cpu_rdata = bank_rd_q;
    endcase
  end
endmodule

module memmap_decoder_chk #(
  parameter int VRAM_AW = 14,
  parameter int WRAM_AW = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic [15:0]        cpu_addr,
  input logic [7:0]         cpu_rdata,
  input logic               cpu_rvalid,
  input logic               cart_req,
  input logic               vram_en,
  input logic [VRAM_AW-1:0] vram_addr,
  input logic               wram_en,
  input logic [WRAM_AW-1:0] wram_addr,
  input logic               oam_en,
  input logic               hram_en
);
  // R12
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cart_req, vram_en, wram_en, oam_en, hram_en}));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !(cart_req || vram_en || wram_en || oam_en || hram_en));
  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> cpu_rvalid);
  // R11
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_req && !cpu_we));
  // R7
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_addr[15:8] == 8'hFE && cpu_addr[7:0] >= 8'hA0) |=> cpu_rdata == 8'hFF);
  // R4
  wbank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wram_en && cpu_addr[15:12] == 4'hD) |-> wram_addr[WRAM_AW-1:12] != '0);
  // R2
  vram_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_en |-> vram_addr[12:0] == cpu_addr[12:0]);
endmodule

bind memmap_decoder memmap_decoder_chk #(.VRAM_AW(VRAM_AW), .WRAM_AW(WRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cart_req(cart_req),
  .vram_en(vram_en), .vram_addr(vram_addr), .wram_en(wram_en), .wram_addr(wram_addr),
  .oam_en(oam_en), .hram_en(hram_en)
);

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid, mem_we;
  logic [7:0]  mem_wdata;
  logic        cart_req, vram_en, wram_en, oam_en, hram_en;
  logic [15:0] cart_addr;
  logic [13:0] vram_addr;
  logic [14:0] wram_addr;
  logic [7:0]  oam_addr, hram_addr;
  logic [7:0]  cart_rdata = '0, vram_rdata = '0, wram_rdata = '0, oam_rdata = '0, hram_rdata = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  memmap_decoder u_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .cart_req(cart_req), .cart_addr(cart_addr), .cart_rdata(cart_rdata),
    .vram_en(vram_en), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
    .wram_en(wram_en), .wram_addr(wram_addr), .wram_rdata(wram_rdata),
    .oam_en(oam_en), .oam_addr(oam_addr), .oam_rdata(oam_rdata),
    .hram_en(hram_en), .hram_addr(hram_addr), .hram_rdata(hram_rdata)
  );

  logic [7:0] cmem [logic [15:0]];
  logic [7:0] vmem [logic [15:0]];
  logic [7:0] wmem [logic [15:0]];
  logic [7:0] omem [logic [15:0]];
  logic [7:0] hmem [logic [15:0]];

  always @(posedge clk) begin
    if (cart_req) begin
      if (mem_we) cmem[cart_addr] = mem_wdata;
      else cart_rdata <= cmem.exists(cart_addr) ? cmem[cart_addr] : 8'h00;
    end
    if (vram_en) begin
      if (mem_we) vmem[16'(vram_addr)] = mem_wdata;
      else vram_rdata <= vmem.exists(16'(vram_addr)) ? vmem[16'(vram_addr)] : 8'h00;
    end
    if (wram_en) begin
      if (mem_we) wmem[16'(wram_addr)] = mem_wdata;
      else wram_rdata <= wmem.exists(16'(wram_addr)) ? wmem[16'(wram_addr)] : 8'h00;
    end
    if (oam_en) begin
      if (mem_we) omem[16'(oam_addr)] = mem_wdata;
      else oam_rdata <= omem.exists(16'(oam_addr)) ? omem[16'(oam_addr)] : 8'h00;
    end
    if (hram_en) begin
      if (mem_we) hmem[16'(hram_addr)] = mem_wdata;
      else hram_rdata <= hmem.exists(16'(hram_addr)) ? hmem[16'(hram_addr)] : 8'h00;
    end
  end

  // {addr, enables {cart,vram,wram,oam,hram}, local address, requirement tag}
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {16'h0000, 5'b10000, 16'h0000, 4'd1},
    {16'h7FFF, 5'b10000, 16'h7FFF, 4'd1},
    {16'hA000, 5'b10000, 16'hA000, 4'd1},
    {16'hBFFF, 5'b10000, 16'hBFFF, 4'd1},
    {16'h8000, 5'b01000, 16'h0000, 4'd2},
    {16'h9FFF, 5'b01000, 16'h1FFF, 4'd2},
    {16'hC000, 5'b00100, 16'h0000, 4'd3},
    {16'hCFFF, 5'b00100, 16'h0FFF, 4'd3},
    {16'hD000, 5'b00100, 16'h1000, 4'd4},
    {16'hDFFF, 5'b00100, 16'h1FFF, 4'd4},
    {16'hE000, 5'b00100, 16'h0000, 4'd5},
    {16'hEFFF, 5'b00100, 16'h0FFF, 4'd5},
    {16'hF000, 5'b00100, 16'h1000, 4'd5},
    {16'hFDFF, 5'b00100, 16'h1DFF, 4'd5},
    {16'hFE00, 5'b00010, 16'h0000, 4'd6},
    {16'hFE9F, 5'b00010, 16'h009F, 4'd6},
    {16'hFEA0, 5'b00000, 16'h0000, 4'd7},
    {16'hFEFF, 5'b00000, 16'h0000, 4'd7},
    {16'hFF00, 5'b00001, 16'h0000, 4'd8},
    {16'hFF80, 5'b00001, 16'h0080, 4'd8},
    {16'hFFFF, 5'b00001, 16'h00FF, 4'd8},
    {16'hFF4F, 5'b00000, 16'h0000, 4'd9}
  };

  function automatic string tag_of(logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [4:0]  p_en;
  logic [15:0] p_loc;
  logic        p_we;

  task automatic probe(logic [15:0] a, logic we, logic [7:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    p_en = {cart_req, vram_en, wram_en, oam_en, hram_en};
    p_we = mem_we;
    case (1'b1)
      cart_req: p_loc = cart_addr;
      vram_en:  p_loc = 16'(vram_addr);
      wram_en:  p_loc = 16'(wram_addr);
      oam_en:   p_loc = 16'(oam_addr);
      hram_en:  p_loc = 16'(hram_addr);
      default:  p_loc = 16'h0000;
    endcase
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    probe(a, 1'b1, d);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d, output logic v);
    probe(a, 1'b0, 8'h00);
    d = cpu_rdata;
    v = cpu_rvalid;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    // R10 / R11 / R12: reset state
    chk("R11", 16'(cpu_rvalid), 16'h0);
    chk("R12", 16'({cart_req, vram_en, wram_en, oam_en, hram_en}), 16'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", 16'({cart_req, vram_en, wram_en, oam_en, hram_en}), 16'h0);
    rd(16'hFF4F, d, v); chk("R10", 16'(d), 16'h00); chk("R11", 16'(v), 16'h1);
    rd(16'hFF70, d, v); chk("R10", 16'(d), 16'h00);

    for (int i = 0; i < NV; i++) begin
      probe(VEC[i][40:25], 1'b0, 8'h00);
      chk(tag_of(VEC[i][3:0]), 16'(p_en), 16'(VEC[i][24:20]));
      chk(tag_of(VEC[i][3:0]), p_loc, VEC[i][19:4]);
    end

    // R1 cart write/read-back and shared write enable
    probe(16'h1234, 1'b1, 8'h12);
    chk("R1", 16'(p_we), 16'h1);
    rd(16'h1234, d, v); chk("R1", 16'(d), 16'h12);

    // R4 bank data isolation
    wr(16'hFF70, 8'h02); wr(16'hD010, 8'h22);
    wr(16'hFF70, 8'h03); wr(16'hD010, 8'h33);
    wr(16'hFF70, 8'h02);
    rd(16'hD010, d, v); chk("R4", 16'(d), 16'h22);
    probe(16'hD010, 1'b0, 8'h00); chk("R4", p_loc, 16'h2010);
    wr(16'hFF70, 8'h00);
    probe(16'hD010, 1'b0, 8'h00); chk("R4", p_loc, 16'h1010);

    // R9 bank register field widths and no target
    probe(16'hFF70, 1'b1, 8'hFA);
    chk("R9", 16'(p_en), 16'h0);
    rd(16'hFF70, d, v); chk("R9", 16'(d), 16'h02);
    probe(16'hD000, 1'b0, 8'h00); chk("R9", p_loc, 16'h2000);
    wr(16'hFF4F, 8'hFF);
    rd(16'hFF4F, d, v); chk("R9", 16'(d), 16'h01);

    // R2 video bank halves
    wr(16'h8005, 8'hB1);
    probe(16'h8005, 1'b0, 8'h00); chk("R2", p_loc, 16'h2005);
    wr(16'hFF4F, 8'h00); wr(16'h8005, 8'hA0);
    rd(16'h8005, d, v); chk("R2", 16'(d), 16'hA0);
    wr(16'hFF4F, 8'h01);
    rd(16'h8005, d, v); chk("R2", 16'(d), 16'hB1);

    // R3 fixed bank ignores work-bank register
    wr(16'hFF70, 8'h05);
    probe(16'hC321, 1'b0, 8'h00); chk("R3", p_loc, 16'h0321);

    // R5 mirror aliasing
    wr(16'hC123, 8'h5C);
    rd(16'hE123, d, v); chk("R5", 16'(d), 16'h5C);
    wr(16'hFF70, 8'h01); wr(16'hF050, 8'h77);
    rd(16'hD050, d, v); chk("R5", 16'(d), 16'h77);
    wr(16'hFF70, 8'h04);
    rd(16'hF050, d, v); chk("R5", 16'(d), 16'h77);

    // R6 / R8 data paths
    wr(16'hFE10, 8'h66);
    rd(16'hFE10, d, v); chk("R6", 16'(d), 16'h66);
    wr(16'hFF80, 8'h81);
    rd(16'hFF80, d, v); chk("R8", 16'(d), 16'h81);

    // R7 hole
    rd(16'hFEA0, d, v); chk("R7", 16'(d), 16'hFF); chk("R7", 16'(v), 16'h1);
    probe(16'hFEA5, 1'b1, 8'h99); chk("R7", 16'(p_en), 16'h0);
    rd(16'hFF4F, d, v); chk("R7", 16'(d), 16'h01);
    rd(16'hFF70, d, v); chk("R7", 16'(d), 16'h04);

    // R11 strobe timing
    wr(16'hC000, 8'h01);
    chk("R11", 16'(cpu_rvalid), 16'h0);
    rd(16'hC000, d, v); chk("R11", 16'(v), 16'h1); chk("R11", 16'(d), 16'h01);
    @(negedge clk);
    chk("R11", 16'(cpu_rvalid), 16'h0);

    done = 1;
    summary();
  end
endmodule